// File: doc/BRIEF.md
# Width-Converting Port With Byte Swap

This block sits between a buffer that stores full 36-bit words and an external port whose transfer width can be 36, 18 or 9 bits. A 36-bit word is treated as four 9-bit bytes. On the write side, narrow transfers arriving at the port are collected into one full word. That word is handed to the buffer in a single push once its last piece has arrived. On the read side, the word at the head of the buffer is cut into narrow transfers. A pop strobe asks the buffer for the next word during the last of those transfers.

An optional byte-order reversal turns the word end for end at byte level, which converts between big-endian and little-endian byte order. The port width and the reversal are plain control inputs and can change at any time without a reset. Each side samples them at the start of a word and keeps using those values until that word has finished. A word that is half assembled or half sent therefore always completes in the format it started with.

Top module: `lane_width_adapter`

## Requirements
- R1: While `rstN` is low and in the first cycle after it rises, `pushValid` is 0. The first transfer after reset on either side is lane 0 of a new word.
- R2: The width code `widthSel` means 2'b00 = 36 bits, 2'b01 = 18 bits, 2'b10 = 9 bits and 2'b11 = 36 bits. A narrow transfer uses bits [w-1:0] of `wrData` and of `rdData`. The unused upper bits of `wrData` are ignored, and the unused upper bits of `rdData` are driven to 0.
- R3: In 36-bit mode, each cycle with `wrValid` high produces `pushValid` high in the next cycle, with `pushWord` equal to the written word (reversed if reversal applies).
- R4: Narrow transfers fill the word least significant lane first: transfer k of a word lands in bits [k*w+w-1 : k*w].
- R5: `pushValid` is high for exactly one cycle. It rises one cycle after the last narrow transfer of a word (transfer 2 in 18-bit mode, transfer 4 in 9-bit mode) and never after an earlier transfer.
- R6: Read transfer k of a word shows bits [k*w+w-1 : k*w] of the head word on `rdData`. `popStrobe` is high, in the same cycle and combinationally, only when `rdReq` is high on the last transfer of a word.
- R7: With `swapEn` applied, byte b (bits [9b+8:9b]) moves to byte 3-b. On the write side the reversal is applied to the assembled word before it is pushed. On the read side it is applied to the head word before it is split.
- R8: `widthSel` and `swapEn` are sampled on the first transfer of each word. A change made in the middle of a word takes effect from the next word on, separately for the write side and the read side.
- R9: A cycle without `wrValid` does not advance the write lane. A cycle without `rdReq` does not advance the read lane and raises no `popStrobe`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| widthSel | input | 2 | Port width code |
| swapEn | input | 1 | Byte-order reversal enable |
| wrValid | input | 1 | A narrow write transfer is present this cycle |
| wrData | input | 36 | Write transfer data, in the low bits |
| pushValid | output | 1 | One-cycle strobe: `pushWord` is a complete word |
| pushWord | output | 36 | Assembled word toward the buffer |
| rdReq | input | 1 | A narrow read transfer is taken this cycle |
| headWord | input | 36 | Word at the head of the buffer |
| rdData | output | 36 | Read transfer data, in the low bits, upper bits 0 |
| popStrobe | output | 1 | Advance the buffer to its next word |

## Verification
The assertions check these rules on every cycle:
- the write and read lane counters never move on idle cycles;
- the sampled width and swap stay frozen while a word is only partly done;
- a push only ever follows a final write transfer;
- the read lane returns to zero after each pop;
- full-width writes push in the very next cycle.

The actual byte placement needs the bench's reference model and directed scenarios, which compare results against literal expected words. This covers lane order, the effect of the reversal on both sides, the zeroing of unused output bits, and mid-word changes of width or swap that must not disturb the word in flight.

// File: rtl/lwa_pkg.sv
package lwa_pkg;
  parameter int BYTE_W    = 9;
  parameter int NUM_BYTES = 4;
  localparam int WORD_W   = BYTE_W * NUM_BYTES;
  localparam int LANE_W   = $clog2(NUM_BYTES);

  typedef logic [NUM_BYTES-1:0][BYTE_W-1:0] byteVec_t;

  // control-to-datapath strobes
  typedef struct packed {
    logic              wrLoad;
    logic              wrLast;
    logic [LANE_W-1:0] wrLane;
    logic [1:0]        wrWidth;
    logic              wrSwap;
    logic [LANE_W-1:0] rdLane;
    logic [1:0]        rdWidth;
    logic              rdSwap;
  } strobe_t;

  function automatic logic [LANE_W-1:0] lastLane(input logic [1:0] width);
    case (width)
      2'b01:   return LANE_W'(1);
      2'b10:   return LANE_W'(NUM_BYTES - 1);
      default: return '0;
    endcase
  endfunction

  function automatic byteVec_t byteSwap(input byteVec_t w);
    byteVec_t r;
    for (int i = 0; i < NUM_BYTES; i++) r[i] = w[NUM_BYTES-1-i];
    return r;
  endfunction
endpackage

// File: rtl/lwa_ctrl.sv
module lwa_ctrl
  import lwa_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] widthSel,
  input  logic       swapEn,
  input  logic       wrValid,
  input  logic       rdReq,
  output strobe_t    st,
  output logic       popStrobe
);
  logic [LANE_W-1:0] wrCnt, rdCnt;
  logic [1:0]        wrWidthQ, rdWidthQ;
  logic              wrSwapQ, rdSwapQ;
  logic [1:0]        wrWidthA, rdWidthA;
  logic              wrSwapA, rdSwapA;
  logic              rdLast;

  // settings are taken live on lane 0, held for the rest of the word
  assign wrWidthA = (wrCnt == '0) ? widthSel : wrWidthQ;
  assign wrSwapA  = (wrCnt == '0) ? swapEn   : wrSwapQ;
  assign rdWidthA = (rdCnt == '0) ? widthSel : rdWidthQ;
  assign rdSwapA  = (rdCnt == '0) ? swapEn   : rdSwapQ;

  assign rdLast    = rdReq && (rdCnt == lastLane(rdWidthA));
  assign popStrobe = rdLast;

  always_comb begin
    st         = '0;
    st.wrLoad  = wrValid;
    st.wrLast  = wrValid && (wrCnt == lastLane(wrWidthA));
    st.wrLane  = wrCnt;
    st.wrWidth = wrWidthA;
    st.wrSwap  = wrSwapA;
    st.rdLane  = rdCnt;
    st.rdWidth = rdWidthA;
    st.rdSwap  = rdSwapA;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrCnt    <= '0;
      wrWidthQ <= '0;
      wrSwapQ  <= 1'b0;
      rdCnt    <= '0;
      rdWidthQ <= '0;
      rdSwapQ  <= 1'b0;
    end else begin
      if (wrValid) begin
        if (wrCnt == '0) begin
          wrWidthQ <= widthSel;
          wrSwapQ  <= swapEn;
        end
        wrCnt <= st.wrLast ? '0 : wrCnt + 1'b1;
      end
      if (rdReq) begin
        if (rdCnt == '0) begin
          rdWidthQ <= widthSel;
          rdSwapQ  <= swapEn;
        end
        rdCnt <= rdLast ? '0 : rdCnt + 1'b1;
      end
    end
  end

  // R9
  wr_idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wrValid |=> $stable(wrCnt));
  // R9
  rd_idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdReq |=> $stable(rdCnt));
  // R8
  wr_width_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrCnt != '0) |=> ($stable(wrWidthQ) && $stable(wrSwapQ)));
  // R8
  rd_width_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdCnt != '0) |=> ($stable(rdWidthQ) && $stable(rdSwapQ)));
  // R5
  wr_lane_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrCnt != '0) |-> (wrCnt <= lastLane(wrWidthQ)));
  // R6
  pop_resets_lane_chk: assert property (@(posedge clk) disable iff (!rstN)
    popStrobe |=> (rdCnt == '0));
endmodule

// File: rtl/lwa_datapath.sv
module lwa_datapath
  import lwa_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           st,
  input  logic [WORD_W-1:0] wrData,
  input  logic [WORD_W-1:0] headWord,
  output logic              pushValid,
  output logic [WORD_W-1:0] pushWord,
  output logic [WORD_W-1:0] rdData
);
  localparam int HALF_BYTES = NUM_BYTES / 2;

  byteVec_t inBytes, acc, nextAcc, view, outBytes;

  assign inBytes = wrData;
  assign view    = st.rdSwap ? byteSwap(headWord) : headWord;
  assign rdData  = outBytes;

  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_pack
    logic              take;
    logic [BYTE_W-1:0] src;
    always_comb begin
      case (st.wrWidth)
        2'b01: begin
          take = (st.wrLane == LANE_W'(b / HALF_BYTES));
          src  = inBytes[b % HALF_BYTES];
        end
        2'b10: begin
          take = (st.wrLane == LANE_W'(b));
          src  = inBytes[0];
        end
        default: begin
          take = 1'b1;
          src  = inBytes[b];
        end
      endcase
      nextAcc[b] = take ? src : acc[b];
    end
  end

  for (genvar j = 0; j < NUM_BYTES; j++) begin : g_unpack
    always_comb begin
      case (st.rdWidth)
        2'b01: begin
          if (j < HALF_BYTES)
            outBytes[j] = view[LANE_W'(int'(st.rdLane) * HALF_BYTES + j)];
          else
            outBytes[j] = '0;
        end
        2'b10: begin
          if (j == 0) outBytes[j] = view[st.rdLane];
          else        outBytes[j] = '0;
        end
        default: outBytes[j] = view[j];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc       <= '0;
      pushValid <= 1'b0;
      pushWord  <= '0;
    end else begin
      pushValid <= st.wrLast;
      if (st.wrLoad) acc <= nextAcc;
      if (st.wrLast) pushWord <= st.wrSwap ? byteSwap(nextAcc) : nextAcc;
    end
  end

  // R5
  push_after_last_chk: assert property (@(posedge clk) disable iff (!rstN)
    pushValid |-> $past(st.wrLast));
endmodule

// File: rtl/lane_width_adapter.sv
module lane_width_adapter
  import lwa_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        widthSel,
  input  logic              swapEn,
  input  logic              wrValid,
  input  logic [WORD_W-1:0] wrData,
  output logic              pushValid,
  output logic [WORD_W-1:0] pushWord,
  input  logic              rdReq,
  input  logic [WORD_W-1:0] headWord,
  output logic [WORD_W-1:0] rdData,
  output logic              popStrobe
);
  strobe_t st;

  lwa_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .widthSel(widthSel), .swapEn(swapEn),
    .wrValid(wrValid), .rdReq(rdReq), .st(st), .popStrobe(popStrobe)
  );

  lwa_datapath u_dp (
    .clk(clk), .rstN(rstN), .st(st), .wrData(wrData), .headWord(headWord),
    .pushValid(pushValid), .pushWord(pushWord), .rdData(rdData)
  );

  // R3
  full_width_push_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && st.wrLane == '0 && (widthSel == 2'b00 || widthSel == 2'b11))
      |=> pushValid);
endmodule

// File: tb/lane_width_adapter_bench.sv
`timescale 1ns/1ps
module lane_width_adapter_bench;
  logic        clk = 1'b0;
  logic        rstN;
  logic [1:0]  widthSel;
  logic        swapEn;
  logic        wrValid;
  logic [35:0] wrData;
  logic        pushValid;
  logic [35:0] pushWord;
  logic        rdReq;
  logic [35:0] headWord;
  logic [35:0] rdData;
  logic        popStrobe;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  bit autoHead = 0;

  // reference model state
  int          mwCnt = 0, mrCnt = 0;
  logic [1:0]  mwW = 0, mrW = 0;
  bit          mwS = 0, mrS = 0;
  logic [35:0] mwAcc = 0, expWord = 0;
  bit          expPush = 0;
  logic [35:0] lastRd;
  bit          lastPop;

  always #2 clk = ~clk;

  lane_width_adapter u_lane_width_adapter (
    .clk(clk), .rstN(rstN), .widthSel(widthSel), .swapEn(swapEn),
    .wrValid(wrValid), .wrData(wrData), .pushValid(pushValid),
    .pushWord(pushWord), .rdReq(rdReq), .headWord(headWord),
    .rdData(rdData), .popStrobe(popStrobe)
  );

  function automatic int perX(input logic [1:0] w);
    if (w == 2'b01) return 2;
    if (w == 2'b10) return 1;
    return 4;
  endfunction

  function automatic logic [35:0] swapB(input logic [35:0] w);
    return {w[8:0], w[17:9], w[26:18], w[35:27]};
  endfunction

  task automatic chk(input string tag, input logic [35:0] got, input logic [35:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic step(input bit wv, input logic [35:0] wd, input bit rr);
    logic [1:0] rw;
    bit rs, ePop;
    int bp;
    logic [35:0] view, eRd;
    wrValid = wv; wrData = wd; rdReq = rr;
    #1;
    rw = (mrCnt == 0) ? widthSel : mrW;
    rs = (mrCnt == 0) ? swapEn : mrS;
    bp = perX(rw);
    view = rs ? swapB(headWord) : headWord;
    eRd = '0;
    for (int j = 0; j < bp; j++) eRd[j*9 +: 9] = view[(mrCnt*bp + j)*9 +: 9];
    ePop = rr && (mrCnt == 4/bp - 1);
    chk("R6 rdData", rdData, eRd);
    chk("R6 popStrobe", {35'd0, popStrobe}, {35'd0, ePop});
    lastRd = rdData; lastPop = popStrobe;
    @(posedge clk);
    expPush = 0;
    if (wv) begin
      if (mwCnt == 0) begin mwW = widthSel; mwS = swapEn; end
      bp = perX(mwW);
      for (int j = 0; j < bp; j++) mwAcc[(mwCnt*bp + j)*9 +: 9] = wd[j*9 +: 9];
      if (mwCnt == 4/bp - 1) begin
        expPush = 1; expWord = mwS ? swapB(mwAcc) : mwAcc; mwCnt = 0;
      end else mwCnt++;
    end
    if (rr) begin
      if (mrCnt == 0) begin mrW = widthSel; mrS = swapEn; end
      if (ePop) mrCnt = 0; else mrCnt++;
    end
    @(negedge clk);
    chk("R5 pushValid", {35'd0, pushValid}, {35'd0, expPush});
    if (expPush) chk("R4 pushWord", pushWord, expWord);
    if (ePop && autoHead) headWord = {4'($urandom), 32'($urandom)};
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rstN = 0; widthSel = 0; swapEn = 0; wrValid = 0; wrData = 0;
    rdReq = 0; headWord = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset pushValid", {35'd0, pushValid}, 36'd0);
    rstN = 1;
    @(negedge clk);
    chk("R1 after reset pushValid", {35'd0, pushValid}, 36'd0);

    // R3 full width
    widthSel = 2'b00; swapEn = 0;
    step(1, 36'h123456789, 0);
    chk("R3 push flag", {35'd0, pushValid}, 36'd1);
    chk("R3 push word", pushWord, 36'h123456789);

    // R4 / R2 half width, junk in upper bits
    widthSel = 2'b01;
    step(1, {18'h3FFFF, 18'h1AAAA}, 0);
    chk("R5 no early push", {35'd0, pushValid}, 36'd0);
    step(1, {18'h2DDDD, 18'h0BBBB}, 0);
    chk("R2 R4 half pack", pushWord, {18'h0BBBB, 18'h1AAAA});

    // R7 byte width with swap
    widthSel = 2'b10; swapEn = 1;
    step(1, {27'h5A5A5A5, 9'h011}, 0);
    step(1, {27'h2222222, 9'h022}, 0);
    step(1, {27'h1111111, 9'h033}, 0);
    chk("R5 no push before lane 3", {35'd0, pushValid}, 36'd0);
    step(1, {27'h7FFFFFF, 9'h044}, 0);
    chk("R7 swapped word", pushWord, {9'h011, 9'h022, 9'h033, 9'h044});

    // R8 mid-word setting change on write side
    widthSel = 2'b10; swapEn = 0;
    step(1, 36'h0A1, 0);
    widthSel = 2'b00; swapEn = 1;
    step(1, 36'h0B2, 0);
    step(1, 36'h0C3, 0);
    chk("R8 width held mid word", {35'd0, pushValid}, 36'd0);
    step(1, 36'h0D4, 0);
    chk("R8 old format word", pushWord, {9'h0D4, 9'h0C3, 9'h0B2, 9'h0A1});
    step(1, 36'h987654321, 0);
    chk("R8 new format word", pushWord, swapB(36'h987654321));

    // R9 idle cycles inside a word
    widthSel = 2'b01; swapEn = 0;
    step(1, 36'h00111, 0);
    step(0, 36'hFFFFFFFFF, 0);
    step(0, 36'hFFFFFFFFF, 0);
    chk("R9 idle no push", {35'd0, pushValid}, 36'd0);
    step(1, 36'h00222, 0);
    chk("R9 word after idle", pushWord, {18'h00222, 18'h00111});

    // R6 byte reads
    headWord = {9'h1C1, 9'h1B2, 9'h1A3, 9'h194};
    widthSel = 2'b10; swapEn = 0;
    step(0, 0, 1); chk("R6 byte 0", lastRd, 36'h194);
    chk("R6 no early pop", {35'd0, lastPop}, 36'd0);
    step(0, 0, 0); chk("R9 read idle", lastRd, 36'h1A3);
    chk("R9 idle no pop", {35'd0, lastPop}, 36'd0);
    step(0, 0, 1); chk("R6 byte 1", lastRd, 36'h1A3);
    step(0, 0, 1); chk("R6 byte 2", lastRd, 36'h1B2);
    step(0, 0, 1); chk("R6 byte 3", lastRd, 36'h1C1);
    chk("R6 pop on last", {35'd0, lastPop}, 36'd1);

    // R7 / R2 half reads with swap
    widthSel = 2'b01; swapEn = 1;
    step(0, 0, 1); chk("R7 R2 swapped low half", lastRd, {18'd0, 9'h1B2, 9'h1C1});
    step(0, 0, 1); chk("R7 swapped high half", lastRd, {18'd0, 9'h194, 9'h1A3});
    chk("R6 half pop", {35'd0, lastPop}, 36'd1);

    // R8 read side mid-word change
    widthSel = 2'b10; swapEn = 0;
    step(0, 0, 1); chk("R8 read byte 0", lastRd, 36'h194);
    widthSel = 2'b00; swapEn = 1;
    step(0, 0, 1); chk("R8 read keeps byte width", lastRd, 36'h1A3);
    step(0, 0, 1);
    step(0, 0, 1); chk("R8 read last byte", lastRd, 36'h1C1);
    step(0, 0, 1); chk("R8 new full read", lastRd, swapB(headWord));

    // mixed traffic against the model
    autoHead = 1;
    for (int i = 0; i < 400; i++) begin
      if ($urandom % 8 == 0) widthSel = 2'($urandom);
      if ($urandom % 8 == 0) swapEn = 1'($urandom);
      step(1'($urandom % 4 != 0), {4'($urandom), 32'($urandom)}, 1'($urandom % 3 != 0));
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule